// File: doc/BRIEF.md
# Instruction Format and Operand Decoder

This block takes one 16-bit instruction word and turns it into the fields the execution stage works from: a 5-bit opcode, the destination and source register indices, a flag for immediate forms, and one 16-bit right-side operand. The low two bits of the word give the format class. The block reads them and rebuilds the full opcode for every immediate form, so each immediate instruction has the same opcode as its register-register twin. Downstream logic then works from the opcode alone and does not need to know the encoding.

The right-side operand comes from one of two places. It is either the register value read for `rs`, or an immediate taken from the word. An immediate is sign-extended, except the memory offset, which is zero-extended. When an immediate prefix is pending, its 12 bits become the upper part of the immediate, and the current word supplies only the low nibble. For loads and stores, the operand is the effective address: word accesses clear bit 0 of the base and scale the offset by two, and byte accesses add the offset unscaled.

The decoder is purely combinational. It holds no state and has no handshake, because it sits inside a pipeline stage and answers the word currently presented. The register file, the prefix register and the execution logic lie outside it.

Top module: `instr_operand_decoder`

## Requirements
- R1: Format 00 (`instr[1:0]`=00, register-register): `opcode`=`instr[6:2]`, `rd_idx`=`instr[15:12]`, `rs_idx`=`instr[11:8]`, `is_imm`=0, and for non-memory opcodes `rsval`=`rs_data`.
- R2: Format 11 (ALU with immediate): `opcode`=16+`instr[5:2]`, `rd_idx`=`instr[15:12]`, `is_imm`=1, and with no prefix `rsval` is `instr[11:6]` sign-extended (-32 gives 0xFFE0).
- R3: Low nibble 0001 decodes to opcode 6 and low nibble 1001 to opcode 7. Both have `rd_idx`=`instr[15:12]`, `is_imm`=1, and with no prefix `rsval` is `instr[11:4]` sign-extended.
- R4: Low five bits 00101 decode to opcode 8 and 10101 to opcode 10. Both have `rd_idx`=0, `is_imm`=1, and `rsval` is `instr[15:5]` sign-extended.
- R5: Low nibble 1101 decodes to opcode 9 with `rd_idx`=0, `is_imm`=1 and `rsval`={`instr[15:4]`,4'h0}.
- R6: Format 10 (memory with offset): `opcode`=12+`instr[3:2]`, `rd_idx`=`instr[15:12]`, `rs_idx`=`instr[11:8]`, `is_imm`=1. The offset is `instr[7:4]` zero-extended.
- R7: For opcodes 12 and 13 (word), `rsval`={`rs_data[15:1]`,0} + 2×offset. For opcodes 14 and 15 (byte), `rsval`=`rs_data`+offset. The register-register form uses offset 0. All sums wrap at 16 bits.
- R8: With `pfx_valid`=1, formats 11 and 10 and the opcode 6/7 forms take {`pfx_value`, low nibble of their own immediate} as the immediate, where the low nibble is `instr[9:6]` for format 11 and `instr[7:4]` for the others. The prefix has no effect on format 00 or on opcodes 8, 9 and 10.
- R9: `rs_idx` is 0 for every immediate form except format 10. Every immediate form has the same opcode as the format-00 word with that opcode in `instr[6:2]`.
- R10: `rs_data` has no effect on `rsval` for any immediate form that is not a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word being decoded |
| rs_data | input | 16 | Register-file read value for the `rs` index |
| pfx_valid | input | 1 | An immediate prefix is pending for this word |
| pfx_value | input | 12 | Upper 12 bits supplied by the pending prefix |
| opcode | output | 5 | Rebuilt full opcode |
| rd_idx | output | 4 | Destination / left source register index |
| rs_idx | output | 4 | Right source register index (0 when unused) |
| is_imm | output | 1 | Operand was taken from the word, not the register |
| rsval | output | 16 | Right-side operand or effective address |

## Verification
Every result is a pure function of the inputs presented in the same cycle, so each output is due zero cycles after its stimulus. The bench applies a new word, register value and prefix state just after a rising edge. It compares all five outputs at the following falling edge, once the combinational paths have settled and before the next change. There is no pipeline to count, so no check waits more than half a period.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int WORD_W = 16;
  localparam int OP_W   = 5;
  localparam int IDX_W  = 4;
  localparam int NIB_W  = 4;
  localparam int PFX_W  = WORD_W - NIB_W;

  typedef enum logic [2:0] {
    FORM_RR  = 3'd0,
    FORM_RI6 = 3'd1,
    FORM_I8  = 3'd2,
    FORM_I11 = 3'd3,
    FORM_I12 = 3'd4,
    FORM_LS  = 3'd5
  } form_e;

  localparam logic [OP_W-1:0] OP_PREFIX  = 5'd9;
  localparam logic [2:0]      OP_MEM_HI  = 3'b011;
  localparam logic [2:0]      OP_BR_HI   = 3'b010;
  localparam logic [3:0]      OP_CONST_HI = 4'b0011;

  function automatic logic form_takes_prefix(input form_e f);
    return (f == FORM_RI6) || (f == FORM_I8) || (f == FORM_LS);
  endfunction

endpackage

// File: rtl/idec_form_classify.sv
module idec_form_classify
  import idec_pkg::*;
(
  input  logic [6:0]      low_bits,
  output form_e           form,
  output logic [OP_W-1:0] opcode
);

  always_comb begin
    form = FORM_RR;
    unique case (low_bits[1:0])
      2'b00: form = FORM_RR;
      2'b11: form = FORM_RI6;
      2'b10: form = FORM_LS;
      default: begin
        unique case (low_bits[3:2])
          2'b01:   form = FORM_I11;
          2'b11:   form = FORM_I12;
          default: form = FORM_I8;
        endcase
      end
    endcase
  end

  always_comb begin
    unique case (form)
      FORM_RR:  opcode = low_bits[6:2];
      FORM_RI6: opcode = {1'b1, low_bits[5:2]};
      FORM_LS:  opcode = {OP_MEM_HI, low_bits[3:2]};
      FORM_I8:  opcode = {OP_CONST_HI, low_bits[3]};
      FORM_I11: opcode = {OP_BR_HI, low_bits[4], 1'b0};
      default:  opcode = OP_PREFIX;
    endcase
  end

endmodule

// File: rtl/idec_imm_build.sv
module idec_imm_build
  import idec_pkg::*;
(
  input  form_e             form,
  input  logic [PFX_W-1:0]  hi_bits,
  input  logic              pfx_valid,
  input  logic [PFX_W-1:0]  pfx_value,
  output logic [WORD_W-1:0] imm_val
);

  localparam int OFS = WORD_W - PFX_W;

  logic [WORD_W-1:0] base_imm;
  logic [NIB_W-1:0]  low_nib;

  function automatic logic [WORD_W-1:0] bit_of(input int pos);
    return {{(WORD_W-1){1'b0}}, hi_bits[pos-OFS]};
  endfunction

  always_comb begin
    base_imm = '0;
    low_nib  = '0;
    unique case (form)
      FORM_RI6: begin
        base_imm = {{(WORD_W-6){hi_bits[11-OFS]}}, hi_bits[11-OFS:6-OFS]};
        low_nib  = hi_bits[9-OFS:6-OFS];
      end
      FORM_I8: begin
        base_imm = {{(WORD_W-8){hi_bits[11-OFS]}}, hi_bits[11-OFS:4-OFS]};
        low_nib  = hi_bits[7-OFS:4-OFS];
      end
      FORM_LS: begin
        base_imm = {{(WORD_W-NIB_W){1'b0}}, hi_bits[7-OFS:4-OFS]};
        low_nib  = hi_bits[7-OFS:4-OFS];
      end
      FORM_I11: begin
        base_imm = {{(WORD_W-11){hi_bits[15-OFS]}}, hi_bits[15-OFS:5-OFS]};
      end
      FORM_I12: begin
        base_imm = {hi_bits, {NIB_W{1'b0}}};
      end
      default: base_imm = '0;
    endcase
  end

  always_comb begin
    if (pfx_valid && form_takes_prefix(form))
      imm_val = {pfx_value, low_nib};
    else
      imm_val = base_imm;
  end

endmodule

// File: rtl/idec_operand_sel.sv
module idec_operand_sel
  import idec_pkg::*;
#(
  parameter int WORD_SCALE_LOG2 = 1
) (
  input  logic              is_mem,
  input  logic              is_word,
  input  logic              is_imm,
  input  logic [WORD_W-1:0] rs_data,
  input  logic [WORD_W-1:0] imm_val,
  output logic [WORD_W-1:0] rsval
);

  logic [WORD_W-1:0] offset;
  logic [WORD_W-1:0] word_base;
  logic [WORD_W-1:0] word_ofs;
  logic [WORD_W-1:0] addr;

  assign offset = is_imm ? imm_val : '0;

  generate
    if (WORD_SCALE_LOG2 == 0) begin : g_unscaled
      assign word_base = rs_data;
      assign word_ofs  = offset;
    end else begin : g_scaled
      assign word_base = {rs_data[WORD_W-1:WORD_SCALE_LOG2], {WORD_SCALE_LOG2{1'b0}}};
      assign word_ofs  = {offset[WORD_W-1-WORD_SCALE_LOG2:0], {WORD_SCALE_LOG2{1'b0}}};
    end
  endgenerate

  assign addr = is_word ? (word_base + word_ofs) : (rs_data + offset);

  always_comb begin
    if (is_mem)      rsval = addr;
    else if (is_imm) rsval = imm_val;
    else             rsval = rs_data;
  end

endmodule

// File: rtl/instr_operand_decoder.sv
module instr_operand_decoder
  import idec_pkg::*;
(
  input  logic [15:0] instr,
  input  logic [15:0] rs_data,
  input  logic        pfx_valid,
  input  logic [11:0] pfx_value,
  output logic [4:0]  opcode,
  output logic [3:0]  rd_idx,
  output logic [3:0]  rs_idx,
  output logic        is_imm,
  output logic [15:0] rsval
);

  form_e             form;
  logic [OP_W-1:0]   op_int;
  logic [WORD_W-1:0] imm_val;
  logic              is_mem;
  logic              is_word;

  idec_form_classify u_class (
    .low_bits (instr[6:0]),
    .form     (form),
    .opcode   (op_int)
  );

  idec_imm_build u_imm (
    .form      (form),
    .hi_bits   (instr[WORD_W-1:NIB_W]),
    .pfx_valid (pfx_valid),
    .pfx_value (pfx_value),
    .imm_val   (imm_val)
  );

  assign is_imm  = (form != FORM_RR);
  assign is_mem  = (op_int[OP_W-1:2] == OP_MEM_HI);
  assign is_word = ~op_int[1];

  idec_operand_sel #(.WORD_SCALE_LOG2(1)) u_sel (
    .is_mem  (is_mem),
    .is_word (is_word),
    .is_imm  (is_imm),
    .rs_data (rs_data),
    .imm_val (imm_val),
    .rsval   (rsval)
  );

  assign opcode = op_int;
  assign rd_idx = (form == FORM_I11 || form == FORM_I12) ? '0 : instr[15:12];
  assign rs_idx = (form == FORM_RR || form == FORM_LS) ? instr[11:8] : '0;

endmodule

// File: rtl/idec_checker.sv
module idec_checker (
  input logic [15:0] instr,
  input logic        pfx_valid,
  input logic [11:0] pfx_value,
  input logic [4:0]  opcode,
  input logic [3:0]  rd_idx,
  input logic        is_imm,
  input logic [15:0] rsval
);

  always_comb begin
    if (instr[1:0] == 2'b00) begin
      p_rr_keeps_opcode_r1: assert (!is_imm && opcode == instr[6:2])
        else $error("rr form opcode or is_imm wrong");
    end
    if (instr[1:0] == 2'b11) begin
      p_alu_imm_upper_r2: assert (is_imm && opcode[4])
        else $error("alu immediate form not in upper opcode half");
    end
    if (instr[1:0] == 2'b11 && pfx_valid) begin
      p_prefix_splice_r8: assert (rsval == {pfx_value, instr[9:6]})
        else $error("prefix splice wrong");
    end
    if (instr[4:0] == 5'b00101 || instr[4:0] == 5'b10101) begin
      p_branch_imm_r4: assert (rd_idx == 4'd0 && rsval[15:10] == {6{instr[15]}})
        else $error("branch immediate form wrong");
    end
    if (instr[3:0] == 4'b1101) begin
      p_prefix_word_r5: assert (opcode == 5'd9 && rsval[3:0] == 4'd0)
        else $error("prefix word decode wrong");
    end
    if (opcode == 5'd12 || opcode == 5'd13) begin
      p_word_even_r7: assert (!rsval[0])
        else $error("word address odd");
    end
  end

endmodule

bind instr_operand_decoder idec_checker u_idec_chk (
  .instr     (instr),
  .pfx_valid (pfx_valid),
  .pfx_value (pfx_value),
  .opcode    (opcode),
  .rd_idx    (rd_idx),
  .is_imm    (is_imm),
  .rsval     (rsval)
);

// File: tb/tb_instr_operand_decoder.sv
module tb_instr_operand_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] rs_data = '0;
  logic        pfx_valid = 1'b0;
  logic [11:0] pfx_value = '0;
  logic [4:0]  opcode;
  logic [3:0]  rd_idx;
  logic [3:0]  rs_idx;
  logic        is_imm;
  logic [15:0] rsval;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct packed {
    logic [4:0]  op;
    logic [3:0]  rd;
    logic [3:0]  rs;
    logic        imm;
    logic [15:0] val;
  } exp_t;

  instr_operand_decoder dut (
    .instr(instr), .rs_data(rs_data), .pfx_valid(pfx_valid), .pfx_value(pfx_value),
    .opcode(opcode), .rd_idx(rd_idx), .rs_idx(rs_idx), .is_imm(is_imm), .rsval(rsval)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(input logic [15:0] w, input logic [15:0] rsd,
                                 input logic pv, input logic [11:0] pval);
    exp_t e;
    logic [15:0] iv;
    logic [15:0] off;
    e.rd = w[15:12]; e.rs = 4'd0; e.imm = 1'b1; e.op = 5'd0; iv = 16'd0;
    if (w[1:0] == 2'b00) begin
      e.op = w[6:2]; e.rs = w[11:8]; e.imm = 1'b0;
    end else if (w[1:0] == 2'b11) begin
      e.op = 5'd16 + {1'b0, w[5:2]};
      iv = pv ? {pval, w[9:6]} : {{10{w[11]}}, w[11:6]};
    end else if (w[1:0] == 2'b10) begin
      e.op = 5'd12 + {3'b0, w[3:2]}; e.rs = w[11:8];
      iv = pv ? {pval, w[7:4]} : {12'h000, w[7:4]};
    end else if (w[3:0] == 4'b0001 || w[3:0] == 4'b1001) begin
      e.op = w[3] ? 5'd7 : 5'd6;
      iv = pv ? {pval, w[7:4]} : {{8{w[11]}}, w[11:4]};
    end else if (w[3:0] == 4'b0101) begin
      e.op = w[4] ? 5'd10 : 5'd8; e.rd = 4'd0;
      iv = {{5{w[15]}}, w[15:5]};
    end else begin
      e.op = 5'd9; e.rd = 4'd0; iv = {w[15:4], 4'h0};
    end
    if (e.op >= 5'd12 && e.op <= 5'd15) begin
      off = e.imm ? iv : 16'd0;
      if (e.op <= 5'd13) e.val = {rsd[15:1], 1'b0} + {off[14:0], 1'b0};
      else               e.val = rsd + off;
    end else begin
      e.val = e.imm ? iv : rsd;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [15:0] w, input logic pv);
    if (w[1:0] == 2'b00) return (w[6:4] == 3'b011) ? "R7" : "R1";
    if (pv && w[1:0] != 2'b01) return "R8";
    if (w[1:0] == 2'b11) return "R2";
    if (w[1:0] == 2'b10) return "R6";
    if (w[2:0] == 3'b001) return "R3";
    if (w[3:0] == 4'b0101) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input exp_t got, input exp_t exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s instr=%h got op=%0d rd=%0d rs=%0d imm=%b val=%h exp op=%0d rd=%0d rs=%0d imm=%b val=%h",
               tag, instr, got.op, got.rd, got.rs, got.imm, got.val,
               exp.op, exp.rd, exp.rs, exp.imm, exp.val);
    end
  endtask

  function automatic exp_t observed();
    exp_t g;
    g.op = opcode; g.rd = rd_idx; g.rs = rs_idx; g.imm = is_imm; g.val = rsval;
    return g;
  endfunction

  task automatic apply(input logic [15:0] w, input logic [15:0] rsd,
                       input logic pv, input logic [11:0] pval, input string tag);
    @(posedge clk);
    instr = w; rs_data = rsd; pfx_valid = pv; pfx_value = pval;
    @(negedge clk);
    check(tag, observed(), model(w, rsd, pv, pval));
  endtask

  task automatic expect_val(input logic [15:0] w, input logic [15:0] rsd, input logic pv,
                            input logic [11:0] pval, input logic [15:0] want, input string tag);
    exp_t g, e;
    @(posedge clk);
    instr = w; rs_data = rsd; pfx_valid = pv; pfx_value = pval;
    @(negedge clk);
    g = observed(); e = g; e.val = want;
    check(tag, g, e);
  endtask

  task automatic twin_check(input logic [15:0] w, input string tag);
    logic [4:0] imm_op;
    exp_t g, e;
    @(posedge clk);
    instr = w; pfx_valid = 1'b0;
    @(negedge clk);
    imm_op = opcode;
    @(posedge clk);
    instr = {8'h5A, 1'b0, imm_op, 2'b00};
    @(negedge clk);
    g = observed(); e = g; e.op = imm_op; e.imm = 1'b0;
    check(tag, g, e);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", observed(), model(16'h0000, 16'h0000, 1'b0, 12'h000));

    // R2: imm6 extremes
    expect_val(16'h3803, 16'h1111, 1'b0, 12'h000, 16'hFFE0, "R2");
    expect_val(16'h37C3, 16'h1111, 1'b0, 12'h000, 16'h001F, "R2");
    // R3: imm8 sign extension, move and loadc
    expect_val(16'h2801, 16'h7777, 1'b0, 12'h000, 16'hFF80, "R3");
    apply(16'h27F9, 16'h7777, 1'b0, 12'h000, "R3");
    // R4: jump/call with prefix pending that must not matter
    expect_val(16'h8005, 16'h0, 1'b1, 12'hABC, 16'hFC00, "R4");
    apply(16'h7FF5, 16'h0, 1'b1, 12'h123, "R4");
    // R5: prefix word ignores incoming prefix
    expect_val(16'h1234 | 16'h000D, 16'h0, 1'b1, 12'hFFF, 16'h1230, "R5");
    // R7: word address clears base bit 0, doubles offset, wraps
    expect_val(16'h12F2, 16'hFFFF, 1'b0, 12'h000, 16'h001C, "R7");
    expect_val(16'h12FA, 16'hFFFF, 1'b0, 12'h000, 16'h000E, "R7");
    expect_val(16'h1230, 16'h0105, 1'b0, 12'h000, 16'h0104, "R7");
    expect_val(16'h1238, 16'h0105, 1'b0, 12'h000, 16'h0105, "R7");
    // R8: splice in ALU and const forms, ignored in rr form
    expect_val(16'h3143, 16'h0, 1'b1, 12'hABC, 16'hABC5, "R8");
    expect_val(16'h3071, 16'h0, 1'b1, 12'h00F, 16'h00F7, "R8");
    expect_val(16'h3140, 16'h4321, 1'b1, 12'hABC, 16'h4321, "R8");
    // R10: rs_data does not reach rsval for non-memory immediate forms
    expect_val(16'h3143, 16'hFFFF, 1'b0, 12'h000, 16'h0005, "R10");
    expect_val(16'h3143, 16'h0000, 1'b0, 12'h000, 16'h0005, "R10");
    // R9: each immediate format against its rr twin
    twin_check(16'h3143, "R9");
    twin_check(16'h30A7, "R9");
    twin_check(16'h2001, "R9");
    twin_check(16'h2009, "R9");
    twin_check(16'h0005, "R9");
    twin_check(16'h0015, "R9");
    twin_check(16'h000D, "R9");
    twin_check(16'h1202, "R9");
    twin_check(16'h120E, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      logic        pv;
      w  = 16'($urandom);
      pv = ($urandom % 3) == 0;
      apply(w, 16'($urandom), pv, 12'($urandom), tag_of(w, pv));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule